// File: doc/BRIEF.md
# Fractional STS-1 VT Compressor

This block accepts the byte stream of a full STS-1 synchronous payload envelope (87 columns by 9 rows, one byte per valid beat) that carries either VT1.5 or VT2 tributaries. Every tributary flagged in a per-VT drop mask is removed, together with the two fixed-stuff columns. The path overhead column passes through. The tributaries that remain keep their original byte interleave. The result is a compressed payload stream for a circuit-emulation packetizer.

For the packet header, the block produces the extension flag and a 32-bit extension word that holds the drop mask of the current envelope. It also rewrites the path parity byte. When the path passes through this node, it ORs in the parity of the bytes it removed. When the path terminates here, it substitutes the parity of the tributary bytes it kept. The mask, the tributary mode, the extension enable and the termination choice are all taken once per envelope, on its first (J1) byte.

Top module: `vt_compress`

## Requirements
- R1: Column 0 (0-based) of every row, the path overhead, is always output. The J1 byte is the one driven with `in_sof_i`, and it is flagged by `out_sof_o`.
- R2: Columns 29 and 58 (0-based) are never output.
- R3: Within each row, the non-overhead, non-stuff columns are numbered k = 0..83 from left to right. Column k belongs to VT index k mod 28 in VT1.5 mode (`vt2_i`=0), or k mod 21 in VT2 mode (`vt2_i`=1). The column is output, in arrival order, exactly when mask bit [index] is 0.
- R4: In VT2 mode, mask bits 21..27 have no effect on the payload and are reported as 0 in the extension word.
- R5: The mask, the mode, the extension enable and the termination select are sampled only on the J1 beat. Changes at any other time do not affect the envelope in progress or the header outputs.
- R6: One cycle after the J1 beat, `hdr_e_o` equals the sampled extension enable. When it is 1, `hdr_ext_o[31:28]` is 0 and `hdr_ext_o[27-i]` holds mask bit i. When it is 0, `hdr_ext_o` is all zero. Both outputs hold until the next J1 beat.
- R7: In pass-through mode (`path_term_i`=0), the byte at row 1, column 0 is output as the input byte ORed with the XOR of all tributary bytes dropped in the previous envelope. This XOR is zero before any envelope has completed.
- R8: In terminate mode (`path_term_i`=1), that byte is replaced by the XOR of all tributary bytes kept in the previous envelope. This XOR is zero before any envelope has completed.
- R9: A kept byte appears on `out_byte_o` with `out_valid_o` high exactly one cycle after its input beat. Beats before the first J1 produce no output, and reset leaves all outputs at zero.
- R10: Cycles with `in_valid_i` low, including any `in_sof_i` asserted on them, produce no output and do not advance the column position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_sof_i | input | 1 | Marks the J1 byte (row 0, column 0) |
| in_byte_i | input | 8 | Envelope byte |
| vt2_i | input | 1 | Tributary mode: 0 VT1.5, 1 VT2 |
| ext_en_i | input | 1 | Emit extension word for this envelope |
| path_term_i | input | 1 | 1 terminate path, 0 pass path through |
| drop_mask_i | input | 28 | Bit i set drops VT index i |
| out_valid_o | output | 1 | Output byte valid |
| out_sof_o | output | 1 | Output byte is J1 |
| out_byte_o | output | 8 | Compressed payload byte |
| hdr_e_o | output | 1 | Extension flag for current envelope |
| hdr_ext_o | output | 32 | Extension word with mask |

## Verification
The checks assume the following about the inputs. `in_sof_i` arrives on a valid beat at row 0, column 0. Envelopes are exactly 783 valid beats long. The configuration inputs may take any value between J1 beats.

The stimulus sends back-to-back envelopes in both modes, under every termination and extension setting. It inserts idle cycles carrying spurious start pulses and drives inverted configuration values on every non-J1 beat, so that the sampling rule is exercised. It also sends stray valid bytes before the first J1. The expected bytes, header words and parity are computed arithmetically from row, column and envelope number.

// File: rtl/vt_compress_pkg.sv
package vt_compress_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned SPE_COLS = 87;
  localparam int unsigned SPE_ROWS = 9;
  localparam int unsigned EXT_ZERO = 4;

  typedef struct packed {
    logic vt2;
    logic ext;
    logic term;
  } frame_cfg_t;
endpackage

// File: rtl/vt_spe_tracker.sv
module vt_spe_tracker #(
  parameter int unsigned COLS    = 87,
  parameter int unsigned ROWS    = 9,
  parameter int unsigned STUFF_A = 29,
  parameter int unsigned STUFF_B = 58,
  parameter int unsigned NVT     = 28,
  parameter int unsigned NVT2    = 21,
  localparam int unsigned CW = $clog2(COLS),
  localparam int unsigned RW = $clog2(ROWS),
  localparam int unsigned IW = $clog2(NVT)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic          sof_i,
  input  logic          vt2_i,
  output logic [RW-1:0] row_o,
  output logic [IW-1:0] idx_o,
  output logic          active_o,
  output logic          is_poh_o,
  output logic          is_stuff_o
);
  logic [CW-1:0] col_q, col_c;
  logic [RW-1:0] row_q;
  logic [IW-1:0] idx_q, idx_max;
  logic          act_q;

  assign col_c      = sof_i ? '0 : col_q;
  assign row_o      = sof_i ? '0 : row_q;
  assign idx_o      = sof_i ? '0 : idx_q;
  assign active_o   = sof_i | act_q;
  assign is_poh_o   = (col_c == '0);
  assign is_stuff_o = (col_c == CW'(STUFF_A)) || (col_c == CW'(STUFF_B));
  assign idx_max    = vt2_i ? IW'(NVT2 - 1) : IW'(NVT - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
      idx_q <= '0;
      act_q <= 1'b0;
    end else if (valid_i && active_o) begin
      act_q <= 1'b1;
      if (col_c == CW'(COLS - 1)) begin
        col_q <= '0;
        row_q <= (row_o == RW'(ROWS - 1)) ? '0 : row_o + 1'b1;
        idx_q <= '0;
      end else begin
        col_q <= col_c + 1'b1;
        row_q <= row_o;
        if (!is_poh_o && !is_stuff_o)
          idx_q <= (idx_o >= idx_max) ? '0 : idx_o + 1'b1;
        else
          idx_q <= idx_o;
      end
    end
  end
endmodule

// File: rtl/vt_parity_acc.sv
module vt_parity_acc #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         keep_en_i,
  input  logic         drop_en_i,
  input  logic [W-1:0] byte_i,
  output logic [W-1:0] keep_par_o,
  output logic [W-1:0] drop_par_o
);
  logic [W-1:0] acc_keep_q, acc_drop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_keep_q <= '0;
      acc_drop_q <= '0;
      keep_par_o <= '0;
      drop_par_o <= '0;
    end else if (clr_i) begin
      keep_par_o <= acc_keep_q;
      drop_par_o <= acc_drop_q;
      acc_keep_q <= '0;
      acc_drop_q <= '0;
    end else begin
      if (keep_en_i) acc_keep_q <= acc_keep_q ^ byte_i;
      if (drop_en_i) acc_drop_q <= acc_drop_q ^ byte_i;
    end
  end
endmodule

// File: rtl/vt_compress.sv
module vt_compress
  import vt_compress_pkg::*;
#(
  parameter int unsigned NVT     = 28,
  parameter int unsigned NVT2    = 21,
  parameter int unsigned STUFF_A = 29,
  parameter int unsigned STUFF_B = 58,
  parameter int unsigned B3_ROW  = 1,
  localparam int unsigned HDR_W = NVT + EXT_ZERO,
  localparam int unsigned RW    = $clog2(SPE_ROWS),
  localparam int unsigned IW    = $clog2(NVT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_sof_i,
  input  logic [BYTE_W-1:0] in_byte_i,
  input  logic              vt2_i,
  input  logic              ext_en_i,
  input  logic              path_term_i,
  input  logic [NVT-1:0]    drop_mask_i,
  output logic              out_valid_o,
  output logic              out_sof_o,
  output logic [BYTE_W-1:0] out_byte_o,
  output logic              hdr_e_o,
  output logic [HDR_W-1:0]  hdr_ext_o
);
  localparam logic [NVT-1:0] VT2_KEEP = {{(NVT-NVT2){1'b0}}, {NVT2{1'b1}}};

  frame_cfg_t       cfg_q;
  logic             vt2_q;
  logic [NVT-1:0]   mask_q, mask_in, mask_rev;
  logic             sof, beat, vt2_cur;
  logic [RW-1:0]    row;
  logic [IW-1:0]    idx;
  logic             active, is_poh, is_stuff, is_vt, drop, keep, is_b3;
  logic [BYTE_W-1:0] keep_par, drop_par, b3_new;

  assign sof     = in_valid_i & in_sof_i;
  assign vt2_cur = sof ? vt2_i : cfg_q.vt2;
  assign vt2_q   = cfg_q.vt2;

  vt_spe_tracker #(
    .COLS(SPE_COLS), .ROWS(SPE_ROWS), .STUFF_A(STUFF_A), .STUFF_B(STUFF_B),
    .NVT(NVT), .NVT2(NVT2)
  ) u_trk (
    .clk_i, .rst_ni,
    .valid_i   (in_valid_i),
    .sof_i     (sof),
    .vt2_i     (vt2_cur),
    .row_o     (row),
    .idx_o     (idx),
    .active_o  (active),
    .is_poh_o  (is_poh),
    .is_stuff_o(is_stuff)
  );

  assign beat  = in_valid_i & active;
  assign is_vt = ~is_poh & ~is_stuff;
  assign drop  = is_vt & mask_q[idx];
  assign keep  = is_poh | (is_vt & ~drop);
  assign is_b3 = is_poh & (row == RW'(B3_ROW));

  vt_parity_acc #(.W(BYTE_W)) u_par (
    .clk_i, .rst_ni,
    .clr_i     (sof),
    .keep_en_i (beat & is_vt & ~drop),
    .drop_en_i (beat & drop),
    .byte_i    (in_byte_i),
    .keep_par_o(keep_par),
    .drop_par_o(drop_par)
  );

  assign b3_new  = cfg_q.term ? keep_par : (in_byte_i | drop_par);
  assign mask_in = vt2_i ? (drop_mask_i & VT2_KEEP) : drop_mask_i;

  // header word carries mask bit 0 right after the zero nibble
  for (genvar i = 0; i < NVT; i++) begin : g_rev
    assign mask_rev[NVT-1-i] = mask_in[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      mask_q    <= '0;
      hdr_e_o   <= 1'b0;
      hdr_ext_o <= '0;
    end else if (sof) begin
      cfg_q     <= '{vt2: vt2_i, ext: ext_en_i, term: path_term_i};
      mask_q    <= mask_in;
      hdr_e_o   <= ext_en_i;
      hdr_ext_o <= ext_en_i ? {{EXT_ZERO{1'b0}}, mask_rev} : '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_sof_o   <= 1'b0;
      out_byte_o  <= '0;
    end else begin
      out_valid_o <= beat & keep;
      out_sof_o   <= sof;
      if (beat && keep) out_byte_o <= is_b3 ? b3_new : in_byte_i;
    end
  end
endmodule

// File: rtl/vt_compress_chk.sv
module vt_compress_chk #(
  parameter int unsigned NVT  = 28,
  parameter int unsigned NVT2 = 21,
  localparam int unsigned HDR_W = NVT + 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_sof_i,
  input logic             out_valid_o,
  input logic             out_sof_o,
  input logic             hdr_e_o,
  input logic [HDR_W-1:0] hdr_ext_o,
  input logic             vt2_q,
  input logic             is_stuff,
  input logic             active
);
  p_out_needs_in_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i));

  p_idle_silent_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);

  p_stuff_dropped_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && active && is_stuff && !in_sof_i) |=> !out_valid_o);

  p_j1_kept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sof_o |-> out_valid_o);

  p_ext_nibble_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_ext_o[HDR_W-1 -: 4] == 4'b0);

  p_ext_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdr_e_o |-> hdr_ext_o == '0);

  p_hdr_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_sof_i) |=> ($stable(hdr_ext_o) && $stable(hdr_e_o)));

  p_vt2_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vt2_q |-> hdr_ext_o[NVT-NVT2-1:0] == '0);
endmodule

bind vt_compress vt_compress_chk #(.NVT(NVT), .NVT2(NVT2)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_sof_i    (in_sof_i),
  .out_valid_o (out_valid_o),
  .out_sof_o   (out_sof_o),
  .hdr_e_o     (hdr_e_o),
  .hdr_ext_o   (hdr_ext_o),
  .vt2_q       (vt2_q),
  .is_stuff    (is_stuff),
  .active      (active)
);

// File: tb/vt_compress_test.sv
`timescale 1ns/1ps
module vt_compress_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0, in_sof_i = 1'b0;
  logic [7:0]  in_byte_i = '0;
  logic        vt2_i = 1'b0, ext_en_i = 1'b0, path_term_i = 1'b0;
  logic [27:0] drop_mask_i = '0;
  logic        out_valid_o, out_sof_o, hdr_e_o;
  logic [7:0]  out_byte_o;
  logic [31:0] hdr_ext_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // pending expectation for the beat driven one cycle earlier
  logic        pv = 0, ps = 0;
  logic [7:0]  pb = '0;
  int          ptag = 0, prow = 0, pcol = 0;
  logic        ph_e = 0;
  logic [31:0] ph_ext = '0;

  // frame configuration and bench parity model
  logic        f_vt2, f_ext, f_term;
  logic [27:0] f_mask;
  logic [7:0]  acc_k = '0, acc_d = '0, prev_k = '0, prev_d = '0;

  always #2.5 clk = ~clk;

  vt_compress uut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid_i), .in_sof_i(in_sof_i),
    .in_byte_i(in_byte_i), .vt2_i(vt2_i), .ext_en_i(ext_en_i), .path_term_i(path_term_i),
    .drop_mask_i(drop_mask_i), .out_valid_o(out_valid_o), .out_sof_o(out_sof_o),
    .out_byte_o(out_byte_o), .hdr_e_o(hdr_e_o), .hdr_ext_o(hdr_ext_o)
  );

  task automatic fail_line(input int tag, input logic [63:0] got, input logic [63:0] exp);
    n_err++;
    $display("FAIL R%0d row %0d col %0d got %h exp %h", tag, prow, pcol, got, exp);
  endtask

  task automatic check_pending();
    n_chk++;
    if (out_valid_o !== pv) fail_line(ptag, 64'(out_valid_o), 64'(pv));
    else if (pv && (out_byte_o !== pb)) fail_line(ptag, 64'(out_byte_o), 64'(pb));
    else if (out_sof_o !== ps) fail_line(1, 64'(out_sof_o), 64'(ps));
    if (ps) begin
      // R6 and R4: header word for the new envelope
      n_chk++;
      if (hdr_e_o !== ph_e || hdr_ext_o !== ph_ext)
        fail_line(6, {31'b0, hdr_e_o, hdr_ext_o}, {31'b0, ph_e, ph_ext});
    end
  endtask

  task automatic step(input logic v, input logic s, input logic [7:0] b, input logic cfg_ok,
                      input logic ev, input logic [7:0] eb, input int tag, input int r, input int c);
    @(negedge clk);
    check_pending();
    in_valid_i  = v;
    in_sof_i    = s;
    in_byte_i   = b;
    // R5: configuration is garbage except on the J1 beat
    vt2_i       = cfg_ok ? f_vt2  : ~f_vt2;
    ext_en_i    = cfg_ok ? f_ext  : ~f_ext;
    path_term_i = cfg_ok ? f_term : ~f_term;
    drop_mask_i = cfg_ok ? f_mask : ~f_mask;
    pv = ev; pb = eb; ps = v && s; ptag = tag; prow = r; pcol = c;
  endtask

  function automatic logic [7:0] gen(input int fr, input int r, input int c);
    return 8'((fr * 53 + r * 29 + c * 7 + (c >> 3)) ^ (r << 5));
  endfunction

  task automatic send_frame(input int fr, input logic vt2, input logic ext,
                            input logic term, input logic [27:0] mask);
    logic [27:0] m_eff;
    f_vt2 = vt2; f_ext = ext; f_term = term; f_mask = mask;
    m_eff = vt2 ? (mask & 28'h01FFFFF) : mask;
    ph_e = ext;
    ph_ext = '0;
    if (ext) for (int i = 0; i < 28; i++) ph_ext[27-i] = m_eff[i];
    prev_k = acc_k; prev_d = acc_d; acc_k = '0; acc_d = '0;
    for (int r = 0; r < 9; r++) begin
      for (int c = 0; c < 87; c++) begin
        logic [7:0] b, eb;
        logic       kp;
        int         tag;
        b = gen(fr, r, c);
        if (((r * 87 + c) % 11) == 5)  // R10: idle beat with a stray start pulse
          step(1'b0, 1'b1, ~b, 1'b0, 1'b0, 8'h00, 10, r, c);
        eb = b;
        if (c == 0) begin
          kp = 1'b1; tag = 1;                        // R1
          if (r == 1) begin
            if (term) begin eb = prev_k; tag = 8; end // R8
            else begin eb = b | prev_d; tag = 7; end  // R7
          end
        end else if (c == 29 || c == 58) begin
          kp = 1'b0; tag = 2;                        // R2
        end else begin
          int k, idx;
          k = c - 1 - ((c > 29) ? 1 : 0) - ((c > 58) ? 1 : 0);
          idx = vt2 ? (k % 21) : (k % 28);
          kp = ~m_eff[idx]; tag = vt2 ? 4 : 3;       // R3, R4
          if (kp) acc_k = acc_k ^ b; else acc_d = acc_d ^ b;
        end
        step(1'b1, (r == 0 && c == 0), b, (r == 0 && c == 0), kp, eb, tag, r, c);
      end
    end
  endtask

  initial begin
    f_vt2 = 0; f_ext = 0; f_term = 0; f_mask = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    n_chk++;
    if (out_valid_o !== 1'b0 || out_sof_o !== 1'b0 || hdr_e_o !== 1'b0 || hdr_ext_o !== '0)
      fail_line(9, {31'b0, out_valid_o, hdr_ext_o}, 64'h0);
    rst_ni = 1'b1;
    // R9: bytes ahead of the first J1 are discarded
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 8'(i * 17 + 3), 1'b0, 1'b0, 8'h00, 9, -1, i);
    send_frame(0, 1'b0, 1'b1, 1'b0, 28'h0000000);
    send_frame(1, 1'b0, 1'b1, 1'b0, 28'h5555555);
    send_frame(2, 1'b0, 1'b1, 1'b1, 28'hFFFFFFF);
    send_frame(3, 1'b1, 1'b1, 1'b0, 28'hFE00F0F);
    send_frame(4, 1'b1, 1'b0, 1'b1, 28'h0123456);
    send_frame(5, 1'b0, 1'b1, 1'b1, 28'h8000001);
    send_frame(6, 1'b0, 1'b0, 1'b0, 28'h0F0F0F0);
    send_frame(7, 1'b1, 1'b1, 1'b0, 28'h01FFFFF);
    send_frame(8, 1'b0, 1'b1, 1'b1, 28'h3C00003);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 10, -1, -1);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 10, -1, -1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule